// File: doc/BRIEF.md
# Two-Tier Cascaded Interrupt Collector

This block gathers level-sensitive interrupt requests from many on-chip modules and reduces them to one request toward a parent interrupt controller. It holds seven identical collector units. Six leaf units each take 32 module interrupt lines. One root unit takes the six leaf outputs and drives the single parent request.

Every unit keeps two 32-bit registers. The pending register records each request line as it is seen, whether or not that line is enabled. The enable register selects which pending bits may raise the unit's output. A unit raises its output one clock after any bit is both pending and enabled. Software reaches the registers of all seven units through one shared register port. A unit select picks the unit and a 4-bit byte offset picks the register inside that unit's 16-byte window. Pending bits are cleared by writing ones to them.

Top module: `irq_cascade`

## Requirements
- R1: After reset, every enable register and every pending register of all units reads 0, and `leafIrq` and `parentIrq` are low.
- R2: A high request line sets its pending bit at the next clock edge even when the matching enable bit is 0. The bit stays set after the line falls.
- R3: A write to offset 0x4 clears each pending bit whose write-data bit is 1 and leaves the bits written 0 unchanged. Writing 0xFFFFFFFF clears every pending bit. Pending bits change only through such a write or a new request.
- R4: If a request line is still high in the cycle its pending bit is written with 1, the bit stays set (set wins over clear).
- R5: A write to offset 0x0 replaces the whole enable register. Reading offset 0x0 returns it, and it changes only through such a write.
- R6: Bit `i` of `leafIrq` is the registered OR of (pending AND enable) of leaf unit `i`. It follows that condition one clock later and stays low while the unit's enable register is 0.
- R7: Bit `i` of the root pending register is set by `leafIrq[i]` for `i` in 0..5. `parentIrq` is the registered OR of the root's (pending AND enable).
- R8: Offsets other than 0x0 and 0x4, and unit selects above 6, read as 0. Writes to them change no register.
- R9: Clearing an enable bit drops the output but keeps the pending bit. Setting the enable bit again raises the output once more.
- R10: A request raised before clock edge 1 shows on `leafIrq` after edge 2 and on `parentIrq` after edge 4, given both tiers are enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| srcIrq | input | 192 | Module request lines; leaf `i` takes bits `[32*i+31:32*i]` |
| regSel | input | 3 | Unit select: 0..5 leaf units, 6 root unit |
| regAddr | input | 4 | Byte offset in the unit window: 0x0 enable, 0x4 pending |
| regWe | input | 1 | Write strobe for the addressed register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data of the addressed register, combinational |
| leafIrq | output | 6 | Registered output of each leaf unit |
| parentIrq | output | 1 | Registered request to the parent controller |

## Verification
A pending bit that is lost or wrongly set shows at the ports in the read data of that unit's pending register at once. It then shows on its tier's output one clock later, and on `parentIrq` up to three clocks later when the tiers are enabled. A wrong enable bit shows only when a pending bit lines up with it, so the bench pairs every enable change with a pending source and watches both outputs. The latency test samples every cycle from the request to the parent line, so a missing or extra register stage shows at the first cycle it touches.

// File: rtl/irq_cascade_pkg.sv
`timescale 1ns/1ps
package irq_cascade_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] OFS_ENABLE = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 4'h4;

  // Write strobes from the decode side to one unit's register datapath.
  typedef struct packed {
    logic enWrite;
    logic stClear;
  } regStrobe_t;
endpackage

// File: rtl/irq_reg_ctl.sv
`timescale 1ns/1ps
module irq_reg_ctl
  import irq_cascade_pkg::*;
#(
  parameter int SEL_W   = 3,
  parameter int UNIT_ID = 0
) (
  input  logic [SEL_W-1:0]  regSel,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  output regStrobe_t        strb
);
  logic unitHit;

  always_comb begin
    unitHit      = (regSel == SEL_W'(UNIT_ID));
    strb.enWrite = unitHit && regWe && (regAddr == OFS_ENABLE);
    strb.stClear = unitHit && regWe && (regAddr == OFS_STATUS);
  end
endmodule

// File: rtl/irq_reg_dp.sv
`timescale 1ns/1ps
module irq_reg_dp
  import irq_cascade_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] srcLvl,
  input  regStrobe_t   strb,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] enableQ,
  output logic [W-1:0] statusQ,
  output logic         irqQ
);
  logic [W-1:0] clrMask;
  logic [W-1:0] statusNext;

  always_comb begin
    clrMask    = strb.stClear ? wrData : '0;
    // a live request outranks a clear in the same cycle
    statusNext = (statusQ & ~clrMask) | srcLvl;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ <= '0;
      statusQ <= '0;
      irqQ    <= 1'b0;
    end else begin
      if (strb.enWrite) enableQ <= wrData;
      statusQ <= statusNext;
      irqQ    <= |(statusQ & enableQ);
    end
  end
endmodule

// File: rtl/irq_cascade.sv
`timescale 1ns/1ps
module irq_cascade
  import irq_cascade_pkg::*;
#(
  parameter int NUM_LEAF = 6,
  parameter int SRC_W    = 32,
  localparam int NUM_UNITS = NUM_LEAF + 1,
  localparam int SEL_W     = $clog2(NUM_UNITS + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_LEAF*SRC_W-1:0] srcIrq,
  input  logic [SEL_W-1:0]          regSel,
  input  logic [ADDR_W-1:0]         regAddr,
  input  logic                      regWe,
  input  logic [SRC_W-1:0]          regWdata,
  output logic [SRC_W-1:0]          regRdata,
  output logic [NUM_LEAF-1:0]       leafIrq,
  output logic                      parentIrq
);
  localparam int ROOT_SEL = NUM_LEAF;

  logic [NUM_UNITS-1:0] unitIrq;
  logic [SRC_W-1:0]     unitEnable [NUM_UNITS];
  logic [SRC_W-1:0]     unitStatus [NUM_UNITS];
  logic [SRC_W-1:0]     rootSrc;

  always_comb begin
    rootSrc                 = '0;
    rootSrc[NUM_LEAF-1:0]   = unitIrq[NUM_LEAF-1:0];
  end

  for (genvar g = 0; g < NUM_UNITS; g++) begin : genUnit
    logic [SRC_W-1:0] unitSrc;
    regStrobe_t       strb;

    if (g < NUM_LEAF) begin : genLeafSrc
      assign unitSrc = srcIrq[g*SRC_W +: SRC_W];
    end else begin : genRootSrc
      assign unitSrc = rootSrc;
    end

    irq_reg_ctl #(.SEL_W(SEL_W), .UNIT_ID(g)) u_ctl (
      .regSel (regSel),
      .regAddr(regAddr),
      .regWe  (regWe),
      .strb   (strb)
    );

    irq_reg_dp #(.W(SRC_W)) u_dp (
      .clk    (clk),
      .rstN   (rstN),
      .srcLvl (unitSrc),
      .strb   (strb),
      .wrData (regWdata),
      .enableQ(unitEnable[g]),
      .statusQ(unitStatus[g]),
      .irqQ   (unitIrq[g])
    );
  end

  always_comb begin
    regRdata = '0;
    if (regSel < SEL_W'(NUM_UNITS)) begin
      if (regAddr == OFS_ENABLE)      regRdata = unitEnable[regSel];
      else if (regAddr == OFS_STATUS) regRdata = unitStatus[regSel];
    end
  end

  assign leafIrq   = unitIrq[NUM_LEAF-1:0];
  assign parentIrq = unitIrq[ROOT_SEL];
endmodule

// File: rtl/irq_cascade_chk.sv
`timescale 1ns/1ps
module irq_cascade_chk
  import irq_cascade_pkg::*;
#(
  parameter int NUM_LEAF = 6,
  parameter int SRC_W    = 32,
  parameter int SEL_W    = 3
) (
  input logic                clk,
  input logic                rstN,
  input logic [SEL_W-1:0]    regSel,
  input logic [ADDR_W-1:0]   regAddr,
  input logic                regWe,
  input logic [NUM_LEAF-1:0] leafIrq,
  input logic                parentIrq,
  input logic [SRC_W-1:0]    rootStatus,
  input logic [SRC_W-1:0]    rootEnable
);
  localparam logic [SEL_W-1:0] ROOT_SEL = SEL_W'(NUM_LEAF);

  logic rootClrWr;
  logic rootEnWr;
  assign rootClrWr = regWe && (regSel == ROOT_SEL) && (regAddr == OFS_STATUS);
  assign rootEnWr  = regWe && (regSel == ROOT_SEL) && (regAddr == OFS_ENABLE);

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (parentIrq == 1'b0 && leafIrq == '0)); // R1

  AST_ROOT_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (leafIrq != '0) |=> ((rootStatus[NUM_LEAF-1:0] & $past(leafIrq)) == $past(leafIrq))); // R7

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !rootClrWr |=> ((rootStatus & $past(rootStatus)) == $past(rootStatus))); // R3

  AST_ENABLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !rootEnWr |=> $stable(rootEnable)); // R5

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (rootEnable == '0) |=> !parentIrq); // R6
endmodule

bind irq_cascade irq_cascade_chk #(
  .NUM_LEAF(NUM_LEAF),
  .SRC_W   (SRC_W),
  .SEL_W   (SEL_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regSel    (regSel),
  .regAddr   (regAddr),
  .regWe     (regWe),
  .leafIrq   (leafIrq),
  .parentIrq (parentIrq),
  .rootStatus(unitStatus[NUM_LEAF]),
  .rootEnable(unitEnable[NUM_LEAF])
);

// File: tb/irq_cascade_tb.sv
`timescale 1ns/1ps
module irq_cascade_tb;
  localparam int NUM_LEAF = 6;
  localparam int SRC_W    = 32;
  localparam int ROOT     = 6;

  typedef struct {
    int          kind;   // 0 read data, 1 leafIrq, 2 parentIrq
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic                      clk = 1'b0;
  logic                      rstN = 1'b0;
  logic [NUM_LEAF*SRC_W-1:0] srcIrq = '0;
  logic [2:0]                regSel = '0;
  logic [3:0]                regAddr = '0;
  logic                      regWe = 1'b0;
  logic [31:0]               regWdata = '0;
  logic [31:0]               regRdata;
  logic [NUM_LEAF-1:0]       leafIrq;
  logic                      parentIrq;

  item_t expQ[$];
  logic  chkPend = 1'b0;
  int    total = 0;
  int    bad = 0;
  bit    done = 1'b0;

  always #2.5 clk = ~clk;

  irq_cascade u_dut (
    .clk(clk), .rstN(rstN), .srcIrq(srcIrq), .regSel(regSel),
    .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata), .leafIrq(leafIrq), .parentIrq(parentIrq)
  );

  task automatic stepBegin();
    @(negedge clk);
    chkPend = 1'b0;
    regWe   = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) stepBegin();
  endtask

  task automatic regWrite(int sel, logic [3:0] addr, logic [31:0] data);
    stepBegin();
    regSel = 3'(sel); regAddr = addr; regWdata = data; regWe = 1'b1;
  endtask

  task automatic setSrc(int leaf, int bitPos, logic val);
    stepBegin();
    srcIrq[leaf*SRC_W + bitPos] = val;
  endtask

  task automatic pushExp(int kind, logic [31:0] exp, string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    expQ.push_back(it);
    chkPend = 1'b1;
  endtask

  task automatic expectRead(int sel, logic [3:0] addr, logic [31:0] exp, string tag);
    stepBegin();
    regSel = 3'(sel); regAddr = addr;
    pushExp(0, exp, tag);
  endtask

  task automatic expectLeaf(logic [5:0] exp, string tag);
    stepBegin();
    pushExp(1, 32'(exp), tag);
  endtask

  task automatic expectParent(logic exp, string tag);
    stepBegin();
    pushExp(2, 32'(exp), tag);
  endtask

  // monitor: samples half a nanosecond before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (chkPend && expQ.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = expQ.pop_front();
        case (it.kind)
          0:       act = regRdata;
          1:       act = 32'(leafIrq);
          default: act = 32'(parentIrq);
        endcase
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;

    // R1 reset state
    expectRead(0, 4'h0, 32'h0, "R1 leaf0 enable");
    expectRead(ROOT, 4'h4, 32'h0, "R1 root pending");
    expectRead(ROOT, 4'h0, 32'h0, "R1 root enable");
    expectLeaf(6'h00, "R1 leafIrq");
    expectParent(1'b0, "R1 parentIrq");

    // R2 raw latch with enable off
    setSrc(2, 3, 1'b1);
    idle(2);
    expectRead(2, 4'h4, 32'h8, "R2 pending while disabled");
    expectLeaf(6'h00, "R2 no output while disabled");
    setSrc(2, 3, 1'b0);
    idle(1);
    expectRead(2, 4'h4, 32'h8, "R2 pending sticky");

    // R5 enable write/readback, R6 leaf output, R7 root latch
    regWrite(2, 4'h0, 32'h8);
    expectRead(2, 4'h0, 32'h8, "R5 enable readback");
    idle(1);
    expectLeaf(6'b000100, "R6 leaf2 raised");
    idle(2);
    expectRead(ROOT, 4'h4, 32'h4, "R7 root pending bit2");
    expectParent(1'b0, "R7 root masked");
    regWrite(ROOT, 4'h0, 32'h4);
    idle(2);
    expectParent(1'b1, "R7 parent raised");

    // R3 write-one-to-clear
    regWrite(2, 4'h4, 32'h0);
    expectRead(2, 4'h4, 32'h8, "R3 zero write keeps");
    regWrite(2, 4'h4, 32'h8);
    expectRead(2, 4'h4, 32'h0, "R3 one write clears");
    idle(2);
    expectLeaf(6'h00, "R6 leaf2 dropped");
    expectRead(ROOT, 4'h4, 32'h4, "R3 root pending sticky");
    expectParent(1'b1, "R3 parent held by root pending");
    regWrite(ROOT, 4'h4, 32'hFFFF_FFFF);
    idle(2);
    expectRead(ROOT, 4'h4, 32'h0, "R3 all-ones clear");
    expectParent(1'b0, "R3 parent dropped");

    // R4 set beats clear
    setSrc(0, 0, 1'b1);
    idle(1);
    regWrite(0, 4'h4, 32'h1);
    expectRead(0, 4'h4, 32'h1, "R4 set wins over clear");
    setSrc(0, 0, 1'b0);
    regWrite(0, 4'h4, 32'h1);
    expectRead(0, 4'h4, 32'h0, "R4 clear after source low");

    // R8 unmapped offsets and selects
    regWrite(1, 4'h8, 32'hFFFF_FFFF);
    regWrite(1, 4'hC, 32'hFFFF_FFFF);
    expectRead(1, 4'h8, 32'h0, "R8 offset 0x8 reads zero");
    expectRead(1, 4'hC, 32'h0, "R8 offset 0xC reads zero");
    expectRead(1, 4'h0, 32'h0, "R8 leaf1 enable untouched");
    expectRead(1, 4'h4, 32'h0, "R8 leaf1 pending untouched");
    regWrite(7, 4'h0, 32'hFFFF_FFFF);
    expectRead(7, 4'h0, 32'h0, "R8 select 7 reads zero");
    expectRead(ROOT, 4'h0, 32'h4, "R8 root enable untouched");
    expectRead(0, 4'h0, 32'h0, "R8 leaf0 enable untouched");

    // R9 masking keeps pending
    regWrite(4, 4'h0, 32'h8000_0000);
    setSrc(4, 31, 1'b1);
    idle(2);
    expectLeaf(6'b010000, "R9 leaf4 raised");
    regWrite(4, 4'h0, 32'h0);
    idle(1);
    expectLeaf(6'h00, "R9 leaf4 masked");
    expectRead(4, 4'h4, 32'h8000_0000, "R9 pending kept while masked");
    regWrite(4, 4'h0, 32'h8000_0000);
    idle(1);
    expectLeaf(6'b010000, "R9 leaf4 restored");
    setSrc(4, 31, 1'b0);
    regWrite(4, 4'h4, 32'h8000_0000);
    regWrite(4, 4'h0, 32'h0);
    idle(2);
    expectLeaf(6'h00, "R9 leaf4 cleared");
    regWrite(ROOT, 4'h4, 32'hFFFF_FFFF);
    idle(1);
    expectParent(1'b0, "R7 bit4 not enabled at root");

    // R10 cycle-exact latency through both tiers
    regWrite(5, 4'h0, 32'h80);
    regWrite(ROOT, 4'h0, 32'h20);
    idle(2);
    expectRead(ROOT, 4'h4, 32'h0, "R10 root pending idle");
    setSrc(5, 7, 1'b1);
    expectLeaf(6'h00, "R10 leaf low after edge 1");
    expectLeaf(6'b100000, "R10 leaf high after edge 2");
    expectParent(1'b0, "R10 parent low after edge 3");
    expectParent(1'b1, "R10 parent high after edge 4");
    setSrc(5, 7, 1'b0);
    regWrite(5, 4'h4, 32'hFFFF_FFFF);
    idle(1);
    regWrite(ROOT, 4'h4, 32'hFFFF_FFFF);
    idle(2);
    expectParent(1'b0, "R3 parent cleared after tier clears");

    idle(2);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule